// File: doc/BRIEF.md
# Serial Save-Memory Responder

This block models, one byte at a time, the save chip found behind a serial peripheral link: a small EEPROM or a flash part. The link controller hands it each received byte, together with the byte's index inside the current chip-select frame and a flag that marks the frame's final byte. One cycle later the block returns the byte to be shifted back out. The first byte of every frame selects the operation. Address bytes follow, most significant first. Data bytes then read or change a small internal array.

A parameter picks one of three personalities. The tiny EEPROM takes a single address byte, and its command code chooses the lower or upper half of the array. The standard EEPROM takes a configurable number of address bytes. Flash takes three address bytes and adds an identification read and a page erase. All three share the status register. Its bit 1 is the write-enable latch: it gates every store and erase, and it drops at the end of each store or erase frame.

Top module: `spisave_responder`

## Requirements
- R1: After reset, reply_valid and reply_byte are 0, the status register is 0x00 and every memory byte reads 0xFF.
- R2: Each cycle with xfer_valid high produces exactly one cycle of reply_valid high in the following cycle. With no transfer, reply_valid stays low.
- R3: The byte at position 0 is taken as the command, and the reply to it is 0x00.
- R4: Command 0x06 sets status bit 1 and command 0x04 clears it.
- R5: In a 0x01 frame, the byte at position 1 rewrites the status register. Bit 0 is kept, bits 2 and 3 are copied from that byte, and every other bit is cleared.
- R6: In a 0x05 frame, every byte after position 0 replies with the status register. The tiny variant ORs 0xF0 into that reply.
- R7: Address bytes start at position 1 and are taken most significant first. The tiny variant takes 1 address byte, the standard EEPROM takes EE_ADDR_BYTES (default 2) and flash takes 3. Each address byte replies 0x00.
- R8: In a 0x03 frame, each byte after the address replies with the memory byte at the current address, and the address then increments. The address wraps from MEM_BYTES-1 to 0.
- R9: In a 0x02 frame, each byte after the address is stored at the current address, and the address then increments. Nothing is stored unless status bit 1 was set when the frame's command byte arrived.
- R10: The last byte of a store (0x02, tiny 0x0A) or erase (0xDB) frame clears status bit 1. A data byte arriving in that same last cycle is still stored.
- R11: The tiny variant reads and stores the lower half of the array with 0x03 and 0x02, and the upper half with 0x0B and 0x0A. Command bit 3 becomes the top address bit.
- R12: The flash variant replies to 0x9F with ID_CODE[23:16], [15:8] and [7:0] at positions 1 to 3, and 0x00 after that. Command 0xDB, once write-enabled, sets every byte of the PAGE_BYTES page holding its 3-byte address to 0xFF, on the third address byte.
- R13: A command the variant does not know replies 0x00 on every byte and changes neither the status nor the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_valid | input | 1 | A received byte is presented this cycle |
| rx_byte | input | 8 | Received byte |
| byte_pos | input | POS_W | Index of the byte inside its frame |
| last_byte | input | 1 | This byte ends the frame |
| reply_valid | output | 1 | reply_byte holds the answer to the previous transfer |
| reply_byte | output | 8 | Byte returned to the link |

## Verification
Two events can land in the same cycle. The final data byte of a store frame must be written, and on that same byte the write-enable latch is cleared. The benches provoke this by ending every enabled store frame on a data byte. They then read the status register back and expect bit 1 low, and read the array back and expect the final byte present. The same check runs for a flash erase whose last address byte both triggers the erase and closes the frame.

// File: rtl/spisave_pkg.sv
package spisave_pkg;

  localparam int unsigned VAR_TINY   = 0;
  localparam int unsigned VAR_EEPROM = 1;
  localparam int unsigned VAR_FLASH  = 2;

  localparam logic [7:0] OP_WRSR    = 8'h01;
  localparam logic [7:0] OP_PROG    = 8'h02;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_WRDI    = 8'h04;
  localparam logic [7:0] OP_RDSR    = 8'h05;
  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_PROG_HI = 8'h0A;
  localparam logic [7:0] OP_READ_HI = 8'h0B;
  localparam logic [7:0] OP_RDID    = 8'h9F;
  localparam logic [7:0] OP_ERASE   = 8'hDB;

  typedef enum logic [2:0] {
    K_NONE, K_CTRL, K_WRSR, K_RDSR, K_READ, K_PROG, K_RDID, K_ERASE
  } op_kind_e;

  // Map a command code to its operation class for one variant.
  function automatic op_kind_e classify(int unsigned variant, logic [7:0] op);
    op_kind_e k;
    k = K_NONE;
    case (op)
      OP_WREN, OP_WRDI: k = K_CTRL;
      OP_WRSR:          k = K_WRSR;
      OP_RDSR:          k = K_RDSR;
      OP_READ:          k = K_READ;
      OP_PROG:          k = K_PROG;
      OP_READ_HI:       k = (variant == VAR_TINY)  ? K_READ  : K_NONE;
      OP_PROG_HI:       k = (variant == VAR_TINY)  ? K_PROG  : K_NONE;
      OP_RDID:          k = (variant == VAR_FLASH) ? K_RDID  : K_NONE;
      OP_ERASE:         k = (variant == VAR_FLASH) ? K_ERASE : K_NONE;
      default:          k = K_NONE;
    endcase
    return k;
  endfunction

  // Number of address bytes that follow an addressed command.
  function automatic int unsigned addr_len(int unsigned variant, int unsigned ee_len);
    if (variant == VAR_TINY)  return 1;
    if (variant == VAR_FLASH) return 3;
    return ee_len;
  endfunction

  // New status value after a status write.
  function automatic logic [7:0] status_after_write(logic [7:0] s, logic [7:0] v);
    return (s & 8'h01) | (v & 8'h0C);
  endfunction

  // Status value as returned to the link.
  function automatic logic [7:0] status_view(int unsigned variant, logic [7:0] s);
    return (variant == VAR_TINY) ? (s | 8'hF0) : s;
  endfunction

endpackage

// File: rtl/spisave_status.sv
module spisave_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_wren,
  input  logic       ev_wrdi,
  input  logic       ev_wrsr,
  input  logic [7:0] wrsr_val,
  input  logic       ev_wel_clear,
  output logic [7:0] stat_q
);
  import spisave_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= 8'h00;
    end else if (ev_wel_clear) begin
      stat_q[1] <= 1'b0;
    end else if (ev_wrsr) begin
      stat_q <= status_after_write(stat_q, wrsr_val);
    end else if (ev_wren) begin
      stat_q[1] <= 1'b1;
    end else if (ev_wrdi) begin
      stat_q[1] <= 1'b0;
    end
  end

endmodule

// File: rtl/spisave_store.sv
module spisave_store #(
  parameter int unsigned AW         = 9,
  parameter int unsigned PAGE_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          erase,
  input  logic [AW-1:0] eaddr,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PW    = $clog2(PAGE_BYTES);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (erase) begin
      for (int i = 0; i < DEPTH; i++) begin
        if ((AW'(i) >> PW) == (eaddr >> PW)) cells[i] <= 8'hFF;
      end
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/spisave_frame_ctl.sv
module spisave_frame_ctl #(
  parameter int unsigned VARIANT       = 2,
  parameter int unsigned AW            = 9,
  parameter int unsigned POS_W         = 8,
  parameter int unsigned EE_ADDR_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_valid,
  input  logic [7:0]       rx_byte,
  input  logic [POS_W-1:0] byte_pos,
  input  logic             last_byte,
  input  logic             wel_now,
  output logic             ev_cmd,
  output logic             ev_addr,
  output logic             ev_wren,
  output logic             ev_wrdi,
  output logic             ev_wrsr,
  output logic             ev_rdsr,
  output logic             ev_read,
  output logic             ev_write,
  output logic             ev_erase,
  output logic             ev_id,
  output logic             ev_wel_clear,
  output logic [1:0]       id_sel,
  output logic [AW-1:0]    addr_q,
  output logic [AW-1:0]    erase_addr,
  output logic             wel_frame
);
  import spisave_pkg::*;

  localparam int unsigned NAB = addr_len(VARIANT, EE_ADDR_BYTES);
  localparam logic [POS_W-1:0] POS_ONE  = POS_W'(1);
  localparam logic [POS_W-1:0] POS_NAB  = POS_W'(NAB);
  localparam logic [POS_W-1:0] POS_ID_L = POS_W'(3);

  logic [7:0]    cmd_q;
  logic          wel_frame_q;
  logic [7:0]    op;
  op_kind_e      kind;
  logic          addressed;
  logic          in_data;
  logic [AW-1:0] addr_next;

  assign ev_cmd    = xfer_valid && (byte_pos == '0);
  assign op        = ev_cmd ? rx_byte : cmd_q;
  assign kind      = classify(VARIANT, op);
  assign addressed = (kind == K_READ) || (kind == K_PROG) || (kind == K_ERASE);

  assign ev_addr   = xfer_valid && !ev_cmd && addressed && (byte_pos <= POS_NAB);
  assign in_data   = xfer_valid && addressed && (byte_pos > POS_NAB);

  assign ev_wren   = ev_cmd && (rx_byte == OP_WREN);
  assign ev_wrdi   = ev_cmd && (rx_byte == OP_WRDI);
  assign ev_wrsr   = xfer_valid && (kind == K_WRSR) && (byte_pos == POS_ONE);
  assign ev_rdsr   = xfer_valid && !ev_cmd && (kind == K_RDSR);
  assign ev_id     = xfer_valid && !ev_cmd && (kind == K_RDID) && (byte_pos <= POS_ID_L);
  assign id_sel    = byte_pos[1:0];
  assign ev_read   = in_data && (kind == K_READ);
  assign ev_write  = in_data && (kind == K_PROG) && wel_frame_q;
  assign ev_erase  = xfer_valid && (kind == K_ERASE) && (byte_pos == POS_NAB) && wel_frame_q;
  assign ev_wel_clear = xfer_valid && last_byte && ((kind == K_PROG) || (kind == K_ERASE));

  assign erase_addr = AW'({addr_q, rx_byte});
  assign wel_frame  = wel_frame_q;

  generate
    if (VARIANT == VAR_TINY) begin : g_tiny_addr
      assign addr_next = AW'({op[3], rx_byte});
    end else begin : g_wide_addr
      assign addr_next = (byte_pos == POS_ONE) ? AW'(rx_byte) : AW'({addr_q, rx_byte});
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q       <= 8'h00;
      wel_frame_q <= 1'b0;
      addr_q      <= '0;
    end else begin
      if (ev_cmd) begin
        cmd_q       <= rx_byte;
        wel_frame_q <= wel_now;
      end
      if (ev_addr) begin
        addr_q <= addr_next;
      end else if (ev_read || ev_write) begin
        addr_q <= addr_q + AW'(1);
      end
    end
  end

endmodule

// File: rtl/spisave_responder.sv
module spisave_responder #(
  parameter int unsigned VARIANT       = 2,
  parameter int unsigned MEM_BYTES     = 512,
  parameter int unsigned PAGE_BYTES    = 16,
  parameter int unsigned EE_ADDR_BYTES = 2,
  parameter int unsigned POS_W         = 8,
  parameter logic [23:0] ID_CODE       = 24'h5A1C07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_valid,
  input  logic [7:0]       rx_byte,
  input  logic [POS_W-1:0] byte_pos,
  input  logic             last_byte,
  output logic             reply_valid,
  output logic [7:0]       reply_byte
);
  import spisave_pkg::*;

  localparam int unsigned AW = $clog2(MEM_BYTES);

  logic          ev_cmd, ev_addr, ev_wren, ev_wrdi, ev_wrsr, ev_rdsr;
  logic          ev_read, ev_write, ev_erase, ev_id, ev_wel_clear;
  logic [1:0]    id_sel;
  logic [AW-1:0] addr_q, erase_addr;
  logic          wel_frame;
  logic [7:0]    stat_q;
  logic [7:0]    mem_rdata;
  logic [7:0]    reply_d;

  spisave_frame_ctl #(
    .VARIANT(VARIANT), .AW(AW), .POS_W(POS_W), .EE_ADDR_BYTES(EE_ADDR_BYTES)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .rx_byte(rx_byte),
    .byte_pos(byte_pos), .last_byte(last_byte), .wel_now(stat_q[1]),
    .ev_cmd(ev_cmd), .ev_addr(ev_addr), .ev_wren(ev_wren), .ev_wrdi(ev_wrdi),
    .ev_wrsr(ev_wrsr), .ev_rdsr(ev_rdsr), .ev_read(ev_read), .ev_write(ev_write),
    .ev_erase(ev_erase), .ev_id(ev_id), .ev_wel_clear(ev_wel_clear),
    .id_sel(id_sel), .addr_q(addr_q), .erase_addr(erase_addr), .wel_frame(wel_frame)
  );

  spisave_status u_status (
    .clk(clk), .rst_n(rst_n), .ev_wren(ev_wren), .ev_wrdi(ev_wrdi),
    .ev_wrsr(ev_wrsr), .wrsr_val(rx_byte), .ev_wel_clear(ev_wel_clear),
    .stat_q(stat_q)
  );

  spisave_store #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .we(ev_write), .waddr(addr_q), .wdata(rx_byte),
    .erase(ev_erase), .eaddr(erase_addr), .raddr(addr_q), .rdata(mem_rdata)
  );

  always_comb begin
    reply_d = 8'h00;
    if (ev_read) begin
      reply_d = mem_rdata;
    end else if (ev_rdsr) begin
      reply_d = status_view(VARIANT, stat_q);
    end else if (ev_id) begin
      case (id_sel)
        2'd1:    reply_d = ID_CODE[23:16];
        2'd2:    reply_d = ID_CODE[15:8];
        2'd3:    reply_d = ID_CODE[7:0];
        default: reply_d = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reply_valid <= 1'b0;
      reply_byte  <= 8'h00;
    end else begin
      reply_valid <= xfer_valid;
      reply_byte  <= xfer_valid ? reply_d : 8'h00;
    end
  end

endmodule

// File: rtl/spisave_responder_chk.sv
module spisave_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_valid,
  input logic [7:0] rx_byte,
  input logic       reply_valid,
  input logic [7:0] reply_byte,
  input logic [7:0] stat_q,
  input logic       ev_cmd,
  input logic       ev_addr,
  input logic       ev_wrsr,
  input logic       ev_write,
  input logic       ev_wel_clear
);

  AST_REPLY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |=> reply_valid); // R2
  AST_REPLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_valid |=> !reply_valid); // R2
  AST_CMD_REPLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd |=> (reply_byte == 8'h00)); // R3
  AST_ADDR_REPLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr |=> (reply_byte == 8'h00)); // R7
  AST_WRSR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrsr |=> (stat_q[0] == $past(stat_q[0])) && (stat_q[3:2] == $past(rx_byte[3:2]))); // R5
  AST_STORE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |-> stat_q[1]); // R9
  AST_WEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wel_clear |=> !stat_q[1]); // R10

endmodule

bind spisave_responder spisave_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .rx_byte(rx_byte),
  .reply_valid(reply_valid), .reply_byte(reply_byte), .stat_q(stat_q),
  .ev_cmd(ev_cmd), .ev_addr(ev_addr), .ev_wrsr(ev_wrsr), .ev_write(ev_write),
  .ev_wel_clear(ev_wel_clear)
);

// File: tb/spisave_responder_bench.sv
module spisave_responder_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] vld = 3'b000;
  logic [7:0] rx = 8'h00;
  logic [7:0] pos = 8'h00;
  logic       last = 1'b0;
  logic [2:0] rv;
  logic [7:0] rb [3];
  logic [7:0] got [8];
  int         ntests = 0;
  int         nfail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  // index 0: tiny EEPROM, 1: standard EEPROM, 2: flash
  spisave_responder #(.VARIANT(0)) u_tiny (
    .clk(clk), .rst_n(rst_n), .xfer_valid(vld[0]), .rx_byte(rx), .byte_pos(pos),
    .last_byte(last), .reply_valid(rv[0]), .reply_byte(rb[0]));
  spisave_responder #(.VARIANT(1)) u_eeprom (
    .clk(clk), .rst_n(rst_n), .xfer_valid(vld[1]), .rx_byte(rx), .byte_pos(pos),
    .last_byte(last), .reply_valid(rv[1]), .reply_byte(rb[1]));
  spisave_responder #(.VARIANT(2)) u_spisave_responder (
    .clk(clk), .rst_n(rst_n), .xfer_valid(vld[2]), .rx_byte(rx), .byte_pos(pos),
    .last_byte(last), .reply_valid(rv[2]), .reply_byte(rb[2]));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  endtask

  task automatic xfer(input int d, input logic [7:0] b, input int p, input bit l,
                      output logic [7:0] r);
    @(negedge clk);
    rx = b; pos = 8'(p); last = l; vld[d] = 1'b1;
    @(negedge clk);
    vld = 3'b000; last = 1'b0;
    r = rb[d];
    if (rv[d] !== 1'b1) chk("R2", {7'd0, rv[d]}, 8'h01);
  endtask

  task automatic fr(input int d, input int n,
                    input logic [7:0] b0 = 0, input logic [7:0] b1 = 0,
                    input logic [7:0] b2 = 0, input logic [7:0] b3 = 0,
                    input logic [7:0] b4 = 0, input logic [7:0] b5 = 0);
    logic [7:0] t [6];
    t[0] = b0; t[1] = b1; t[2] = b2; t[3] = b3; t[4] = b4; t[5] = b5;
    for (int i = 0; i < n; i++) xfer(d, t[i], i, i == n - 1, got[i]);
    @(negedge clk);
    chk("R2 idle", {7'd0, rv[d]}, 8'h00);
  endtask

  task automatic t_reset();
    chk("R1 valid", {5'd0, rv}, 8'h00);
    chk("R1 reply", rb[2], 8'h00);
    fr(2, 2, 8'h05, 8'h00);
    chk("R1 status", got[1], 8'h00);
    fr(2, 5, 8'h03, 8'h00, 8'h00, 8'h07, 8'h00);
    chk("R1 memory", got[4], 8'hFF);
  endtask

  task automatic t_eeprom_status();
    fr(1, 1, 8'h06);
    fr(1, 2, 8'h05, 8'h00);
    chk("R4 wren", got[1], 8'h02);
    fr(1, 2, 8'h01, 8'hFF);
    fr(1, 2, 8'h05, 8'h00);
    chk("R5 wrsr", got[1], 8'h0C);
    fr(1, 1, 8'h06);
    fr(1, 3, 8'h05, 8'h00, 8'h00);
    chk("R6 rdsr", got[2], 8'h0E);
    fr(1, 1, 8'h04);
    fr(1, 2, 8'h05, 8'h00);
    chk("R4 wrdi", got[1], 8'h0C);
  endtask

  task automatic t_eeprom_data();
    fr(1, 1, 8'h06);
    fr(1, 6, 8'h02, 8'h00, 8'h10, 8'hA1, 8'hB2, 8'hC3);
    chk("R3 cmd reply", got[0], 8'h00);
    chk("R7 addr reply", got[2], 8'h00);
    fr(1, 2, 8'h05, 8'h00);
    chk("R10 wel cleared", got[1], 8'h0C);
    fr(1, 6, 8'h03, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00);
    chk("R7 read addr reply", got[1], 8'h00);
    chk("R8 byte0", got[3], 8'hA1);
    chk("R8 byte1", got[4], 8'hB2);
    chk("R10 last stored", got[5], 8'hC3);
    fr(1, 4, 8'h02, 8'h00, 8'h20, 8'h55);
    fr(1, 4, 8'h03, 8'h00, 8'h20, 8'h00);
    chk("R9 no wel", got[3], 8'hFF);
    fr(1, 1, 8'h06);
    fr(1, 5, 8'h02, 8'h01, 8'hFF, 8'h11, 8'h22);
    fr(1, 5, 8'h03, 8'h01, 8'hFF, 8'h00, 8'h00);
    chk("R8 top", got[3], 8'h11);
    chk("R8 wrap", got[4], 8'h22);
    fr(1, 4, 8'h9F, 8'h00, 8'h00, 8'h00);
    chk("R13 unknown", got[1] | got[2] | got[3], 8'h00);
    fr(1, 2, 8'h05, 8'h00);
    chk("R13 status kept", got[1], 8'h0C);
  endtask

  task automatic t_tiny();
    fr(0, 2, 8'h05, 8'h00);
    chk("R6 tiny view", got[1], 8'hF0);
    fr(0, 2, 8'h01, 8'h0E);
    fr(0, 2, 8'h05, 8'h00);
    chk("R5 tiny wrsr", got[1], 8'hFC);
    fr(0, 1, 8'h06);
    fr(0, 3, 8'h0A, 8'h05, 8'h77);
    chk("R7 tiny addr", got[1], 8'h00);
    fr(0, 3, 8'h03, 8'h05, 8'h00);
    chk("R11 low half", got[2], 8'hFF);
    fr(0, 3, 8'h0B, 8'h05, 8'h00);
    chk("R11 high half", got[2], 8'h77);
    fr(0, 2, 8'h05, 8'h00);
    chk("R10 tiny wel", got[1], 8'hFC);
  endtask

  task automatic t_flash();
    fr(2, 5, 8'h9F, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R12 id0", got[1], 8'h5A);
    chk("R12 id1", got[2], 8'h1C);
    chk("R12 id2", got[3], 8'h07);
    chk("R12 id end", got[4], 8'h00);
    fr(2, 1, 8'h06);
    fr(2, 6, 8'h02, 8'h00, 8'h01, 8'h23, 8'h44, 8'h55);
    fr(2, 6, 8'h03, 8'h00, 8'h01, 8'h23, 8'h00, 8'h00);
    chk("R7 flash addr", got[3], 8'h00);
    chk("R8 flash b0", got[4], 8'h44);
    chk("R8 flash b1", got[5], 8'h55);
    fr(2, 1, 8'h06);
    fr(2, 4, 8'hDB, 8'h00, 8'h01, 8'h20);
    fr(2, 5, 8'h03, 8'h00, 8'h01, 8'h23, 8'h00);
    chk("R12 erased", got[4], 8'hFF);
    fr(2, 2, 8'h05, 8'h00);
    chk("R10 erase wel", got[1], 8'h00);
    fr(2, 1, 8'h06);
    fr(2, 5, 8'h02, 8'h00, 8'h01, 8'h40, 8'h99);
    fr(2, 4, 8'hDB, 8'h00, 8'h01, 8'h40);
    fr(2, 5, 8'h03, 8'h00, 8'h01, 8'h40, 8'h00);
    chk("R9 erase gated", got[4], 8'h99);
    fr(2, 3, 8'h5A, 8'h01, 8'h02);
    chk("R13 flash unknown", got[1] | got[2], 8'h00);
    fr(2, 2, 8'h05, 8'h00);
    chk("R13 flash status", got[1], 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_eeprom_status();
    t_eeprom_data();
    t_tiny();
    t_flash();
    summary();
  end

endmodule